// File: doc/BRIEF.md
# Receive Special-Condition Interrupt Controller

This block sits between the character FIFO of a serial receiver and the chip's interrupt and DMA logic. Each cycle it looks at the character at the FIFO head together with that character's error flags (parity mismatch, overrun, framing). It decides whether the character goes to the DMA engine, whether it raises a receive interrupt, and whether it must be held at the head of the FIFO. The decision uses a two-bit receive-interrupt mode and a parity-counts-as-error enable. The FIFO storage, parity generation and the serial shift logic are outside the block.

In the error-only mode, DMA can be armed before the first character arrives. Every clean character, the first included, then reaches DMA with no CPU involvement. A character with an error raises the interrupt and freezes the FIFO head. The CPU inspects the captured data and status, then issues an error-reset command, which drops the bad character and reopens the flow. The other modes either raise no receive interrupt at all or raise one for every delivered character, with errors only reported in the status.

Top module: `rx_special_ctl`

## Requirements
- R1: In mode 2'b11, a head character with an error is not offered to DMA (dmaReq low, fifoPop low). From the next clock irqPending is 1, and the character stays at the head with dmaReq low until an error-reset command.
- R2: In mode 2'b11, a clean head character raises dmaReq in the same cycle. When dmaAck is also high it is popped (fifoPop high), and irqPending stays 0.
- R3: An error-reset command (cmdStrobe high with cmdCode 2'b01) while a character is held pulses fifoPop in that cycle, which discards the character. Holding and irqPending are cleared at that clock edge.
- R4: An overrun or framing flag always makes the character an error, whatever the parity settings.
- R5: A parity mismatch makes a character an error only when both parityEnable and parityIsSpecial are 1. With parityEnable at 0 the parity flag has no effect, either on the decision or on the status.
- R6: In mode 2'b00, irqPending never rises, and every character, errored or not, is delivered through DMA without being held.
- R7: In modes 2'b01 and 2'b10, every DMA-delivered character sets irqPending from the next clock. Errored characters are delivered too, not held, and are reported through status bit 3.
- R8: The acknowledge command (cmdCode 2'b10) clears irqPending at the next clock. While a character is held it has no effect.
- R9: The synchronous chanReset clears holding, irqPending and rxStatus at the next clock without popping the FIFO. The asynchronous rstN clears all state.
- R10: On every DMA pop or error hold, rxData and rxStatus take the head character from the next clock. rxStatus is {error, framing, overrun, parity} in bits 3 down to 0, and its parity bit is the parity flag gated by parityEnable. An error-reset clears rxStatus.
- R11: cmdCode values 2'b00 and 2'b11 have no effect, even with cmdStrobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanReset | input | 1 | Synchronous channel reset |
| modeSel | input | 2 | Receive-interrupt mode |
| parityEnable | input | 1 | Parity checking enabled |
| parityIsSpecial | input | 1 | Parity mismatch counts as an error |
| fifoValid | input | 1 | FIFO head holds a character |
| fifoData | input | DATA_W | Head character |
| fifoParityErr | input | 1 | Head parity mismatch |
| fifoOverrun | input | 1 | Head overrun flag |
| fifoFramingErr | input | 1 | Head framing flag |
| fifoPop | output | 1 | Remove head character |
| dmaReq | output | 1 | DMA request for head character |
| dmaAck | input | 1 | DMA accepts the head character |
| cmdStrobe | input | 1 | Command valid |
| cmdCode | input | 2 | Command code |
| irqPending | output | 1 | Receive interrupt pending |
| rxData | output | DATA_W | Last captured character |
| rxStatus | output | 4 | Last captured status |

## Verification
The bench aims at the errored character that arrives while DMA is already acknowledging. A design that checks errors one cycle late would hand it to DMA and never interrupt. It checks that an error reset discards exactly the held character. A design that fails to pop, or pops twice, would repeat the character or lose the next clean one, and the randomized streams show this when the delivered and discarded lists are compared with the expected split. It drives parity mismatches under each enable combination, where a wrong gate would freeze clean traffic or let bad data through. It also drives acknowledge commands and reserved command codes during a hold, where a sloppy decode would drop the interrupt while the FIFO head stays frozen.

// File: rtl/rx_special_pkg.sv
package rx_special_pkg;

  typedef enum logic [1:0] {
    RX_IRQ_OFF     = 2'b00,
    RX_IRQ_EACH_A  = 2'b01,
    RX_IRQ_EACH_B  = 2'b10,
    RX_IRQ_ERRONLY = 2'b11
  } rxIrqMode_e;

  typedef enum logic [1:0] {
    CMD_NONE      = 2'b00,
    CMD_ERR_RESET = 2'b01,
    CMD_IRQ_ACK   = 2'b10,
    CMD_RESERVED  = 2'b11
  } rxCmd_e;

  // status word reported with every captured character
  typedef struct packed {
    logic special;
    logic framing;
    logic overrun;
    logic parity;
  } rxStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture head character and its status
    logic clearErr;  // error reset: drop status
    logic clearAll;  // channel reset
  } dpCtl_t;

  localparam int STATUS_W = $bits(rxStatus_t);

endpackage

// File: rtl/rx_special_dp.sv
module rx_special_dp
  import rx_special_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              parityErr,
  input  logic              overrunErr,
  input  logic              framingErr,
  input  logic              parityEnable,
  input  logic              parityIsSpecial,
  output logic              headSpecial,
  output logic [DATA_W-1:0] rxData,
  output rxStatus_t         rxStatus
);

  logic      parityCounts;
  logic      parityQual;
  rxStatus_t headStatus;

  // parity only matters when checking is on; only a special when enabled too
  assign parityQual   = parityErr && parityEnable;
  assign parityCounts = parityQual && parityIsSpecial;
  assign headSpecial  = overrunErr || framingErr || parityCounts;

  always_comb begin
    headStatus.special = headSpecial;
    headStatus.framing = framingErr;
    headStatus.overrun = overrunErr;
    headStatus.parity  = parityQual;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxStatus <= '0;
    end else if (ctl.clearAll) begin
      rxStatus <= '0;
    end else if (ctl.load) begin
      rxData   <= fifoData;
      rxStatus <= headStatus;
    end else if (ctl.clearErr) begin
      rxStatus <= '0;
    end
  end

  // R4: overrun or framing always reports as special once captured
  p_hard_err_special_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.clearAll && (overrunErr || framingErr)) |=> rxStatus.special);

  // R5: a captured parity bit never appears while checking is off
  p_parity_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.clearAll && !parityEnable) |=> !rxStatus.parity);

endmodule

// File: rtl/rx_special_ctrl.sv
module rx_special_ctrl
  import rx_special_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanReset,
  input  logic [1:0] modeSel,
  input  logic       fifoValid,
  input  logic       headSpecial,
  input  logic       dmaAck,
  input  logic       cmdStrobe,
  input  logic [1:0] cmdCode,
  output logic       dmaReq,
  output logic       fifoPop,
  output logic       irqPending,
  output dpCtl_t     ctl
);

  rxIrqMode_e mode;
  logic held;
  logic errOnly;
  logic eachChar;
  logic errReset;
  logic irqAck;
  logic holdNow;
  logic dmaPop;
  logic discard;
  logic irqSet;

  assign mode     = rxIrqMode_e'(modeSel);
  assign errOnly  = (mode == RX_IRQ_ERRONLY);
  assign eachChar = (mode == RX_IRQ_EACH_A) || (mode == RX_IRQ_EACH_B);
  assign errReset = cmdStrobe && (rxCmd_e'(cmdCode) == CMD_ERR_RESET);
  assign irqAck   = cmdStrobe && (rxCmd_e'(cmdCode) == CMD_IRQ_ACK);

  assign holdNow  = fifoValid && headSpecial && errOnly && !held;
  assign dmaReq   = fifoValid && !held && !(errOnly && headSpecial);
  assign dmaPop   = dmaReq && dmaAck;
  assign discard  = held && errReset;
  assign fifoPop  = dmaPop || discard;
  assign irqSet   = holdNow || (eachChar && dmaPop);

  always_comb begin
    ctl.load     = dmaPop || holdNow;
    ctl.clearErr = errReset;
    ctl.clearAll = chanReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= 1'b0;
    end else if (chanReset || discard) begin
      held <= 1'b0;
    end else if (holdNow) begin
      held <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (chanReset) begin
      irqPending <= 1'b0;
    end else if (irqSet) begin
      irqPending <= 1'b1;
    end else if (errReset || (irqAck && !held)) begin
      irqPending <= 1'b0;
    end
  end

  // R1: a held character is never offered to DMA
  p_hold_blocks_dma_r1: assert property (@(posedge clk) disable iff (!rstN)
    held |-> !dmaReq);

  // R1: a hold always carries a pending interrupt
  p_hold_has_irq_r1: assert property (@(posedge clk) disable iff (!rstN)
    held |-> irqPending);

  // R2: a pop is either a DMA transfer or a discard of a held character
  p_pop_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> ((dmaReq && dmaAck) || held));

  // R3: error reset on a hold releases it and drops the interrupt
  p_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (held && errReset) |=> (!held && !irqPending));

  // R6: interrupts stay quiet in the disabled mode
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == RX_IRQ_OFF && !irqPending) |=> !irqPending);

  // R7: each delivered character interrupts in the per-character modes
  p_each_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (eachChar && dmaPop && !chanReset) |=> irqPending);

  // R9: channel reset clears hold and interrupt
  p_chan_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    chanReset |=> (!held && !irqPending));

endmodule

// File: rtl/rx_special_ctl.sv
module rx_special_ctl
  import rx_special_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanReset,
  input  logic [1:0]        modeSel,
  input  logic              parityEnable,
  input  logic              parityIsSpecial,
  input  logic              fifoValid,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoParityErr,
  input  logic              fifoOverrun,
  input  logic              fifoFramingErr,
  output logic              fifoPop,
  output logic              dmaReq,
  input  logic              dmaAck,
  input  logic              cmdStrobe,
  input  logic [1:0]        cmdCode,
  output logic              irqPending,
  output logic [DATA_W-1:0] rxData,
  output logic [3:0]        rxStatus
);

  dpCtl_t    ctl;
  logic      headSpecial;
  rxStatus_t statusWord;

  rx_special_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .chanReset   (chanReset),
    .modeSel     (modeSel),
    .fifoValid   (fifoValid),
    .headSpecial (headSpecial),
    .dmaAck      (dmaAck),
    .cmdStrobe   (cmdStrobe),
    .cmdCode     (cmdCode),
    .dmaReq      (dmaReq),
    .fifoPop     (fifoPop),
    .irqPending  (irqPending),
    .ctl         (ctl)
  );

  rx_special_dp #(.DATA_W(DATA_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .ctl             (ctl),
    .fifoData        (fifoData),
    .parityErr       (fifoParityErr),
    .overrunErr      (fifoOverrun),
    .framingErr      (fifoFramingErr),
    .parityEnable    (parityEnable),
    .parityIsSpecial (parityIsSpecial),
    .headSpecial     (headSpecial),
    .rxData          (rxData),
    .rxStatus        (statusWord)
  );

  assign rxStatus = statusWord;

endmodule

// File: tb/test_rx_special_ctl.sv
module test_rx_special_ctl;

  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanReset = 1'b0;
  logic [1:0] modeSel = 2'b11;
  logic parityEnable = 1'b1;
  logic parityIsSpecial = 1'b1;
  logic fifoValid;
  logic [DATA_W-1:0] fifoData;
  logic fifoParityErr, fifoOverrun, fifoFramingErr;
  logic fifoPop, dmaReq, irqPending;
  logic dmaAck = 1'b0;
  logic cmdStrobe = 1'b0;
  logic [1:0] cmdCode = 2'b00;
  logic [DATA_W-1:0] rxData;
  logic [3:0] rxStatus;

  int total = 0;
  int bad = 0;

  // bench FIFO model; flags are {framing, overrun, parity}
  logic [DATA_W-1:0] qData [0:511];
  logic [2:0]        qFlag [0:511];
  logic [8:0] qHead = '0;
  logic [8:0] qTail = '0;

  logic [DATA_W-1:0] dlv [0:511];
  logic [DATA_W-1:0] dsc [0:511];
  int dCnt = 0;
  int sCnt = 0;

  always #5 clk = ~clk;

  assign fifoValid      = (qHead != qTail);
  assign fifoData       = qData[qHead];
  assign fifoParityErr  = fifoValid && qFlag[qHead][0];
  assign fifoOverrun    = fifoValid && qFlag[qHead][1];
  assign fifoFramingErr = fifoValid && qFlag[qHead][2];

  rx_special_ctl #(.DATA_W(DATA_W)) i_rx_special_ctl (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .modeSel(modeSel),
    .parityEnable(parityEnable), .parityIsSpecial(parityIsSpecial),
    .fifoValid(fifoValid), .fifoData(fifoData), .fifoParityErr(fifoParityErr),
    .fifoOverrun(fifoOverrun), .fifoFramingErr(fifoFramingErr),
    .fifoPop(fifoPop), .dmaReq(dmaReq), .dmaAck(dmaAck),
    .cmdStrobe(cmdStrobe), .cmdCode(cmdCode), .irqPending(irqPending),
    .rxData(rxData), .rxStatus(rxStatus)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (dmaReq && dmaAck) begin dlv[dCnt] = fifoData; dCnt++; end
      if (fifoPop && !(dmaReq && dmaAck)) begin dsc[sCnt] = fifoData; sCnt++; end
      if (fifoPop) qHead <= qHead + 9'd1;
    end
  end

  function automatic bit isSpec(input logic [2:0] f, input logic pe, input logic pis);
    return f[2] || f[1] || (f[0] && pe && pis);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic push(input logic [DATA_W-1:0] d, input logic [2:0] f);
    qData[qTail] = d; qFlag[qTail] = f; qTail = qTail + 9'd1; #1;
  endtask

  task automatic cmd(input logic [1:0] c);
    cmdStrobe = 1'b1; cmdCode = c; tick(); cmdStrobe = 1'b0; cmdCode = 2'b00; #1;
  endtask

  task automatic errResetHeld();
    cmdStrobe = 1'b1; cmdCode = 2'b01; #1;
    chk("R3 discard pop", fifoPop, 1);
    tick(); cmdStrobe = 1'b0; cmdCode = 2'b00; #1;
    chk("R3 irq cleared", irqPending, 0);
    chk("R10 status cleared", rxStatus, 0);
  endtask

  task automatic runRound(input logic pe, input logic pis, input int n);
    logic [8:0] start;
    int ei, si, guard;
    modeSel = 2'b11; parityEnable = pe; parityIsSpecial = pis;
    dCnt = 0; sCnt = 0; start = qTail;
    for (int i = 0; i < n; i++) begin
      logic [2:0] f;
      f = ($urandom % 8 < 5) ? 3'b000 : 3'($urandom % 7 + 1);
      qData[qTail] = DATA_W'($urandom); qFlag[qTail] = f; qTail = qTail + 9'd1;
    end
    guard = 0;
    while (qHead != qTail && guard < 5000) begin
      dmaAck = 1'($urandom % 2); cmdStrobe = 1'b0; cmdCode = 2'b00; #1;
      if (irqPending) begin
        chk("R1 random held status", rxStatus[3], 1);
        chk("R10 random held data", rxData, qData[qHead]);
        cmdStrobe = 1'b1; cmdCode = 2'b01;
      end
      tick(); guard++;
    end
    cmdStrobe = 1'b0; cmdCode = 2'b00; dmaAck = 1'b0; tick();
    ei = 0; si = 0;
    for (int i = 0; i < n; i++) begin
      logic [8:0] k;
      k = start + 9'(i);
      if (isSpec(qFlag[k], pe, pis)) begin
        chk("R3 random discarded char", dsc[si], qData[k]); si++;
      end else begin
        chk("R2 random delivered char", dlv[ei], qData[k]); ei++;
      end
    end
    chk("R2 random delivered count", dCnt, ei);
    chk("R3 random discard count", sCnt, si);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seedSet;
    seedSet = $urandom(32'h5eed);
    repeat (3) tick();
    chk("R9 reset irq", irqPending, 0);
    chk("R9 reset status", rxStatus, 0);
    chk("R9 reset dmaReq", dmaReq, 0);
    rstN = 1'b1; tick();

    // R2 clean char in error-only mode
    push(8'h11, 3'b000);
    chk("R2 clean dmaReq", dmaReq, 1);
    dmaAck = 1'b1; #1;
    chk("R2 clean pop", fifoPop, 1);
    tick();
    chk("R2 no irq", irqPending, 0);
    chk("R10 data captured", rxData, 8'h11);
    chk("R2 fifo drained", dmaReq, 0);

    // R1 / R4 framing char held while DMA acks
    push(8'h22, 3'b100);
    chk("R1 no dmaReq on error", dmaReq, 0);
    chk("R1 no pop on error", fifoPop, 0);
    tick();
    chk("R1 irq set", irqPending, 1);
    chk("R4 framing status", rxStatus, 4'b1100);
    chk("R10 held data", rxData, 8'h22);
    repeat (3) tick();
    chk("R1 still held", irqPending, 1);
    chk("R1 head kept", qHead, qTail - 9'd1);
    cmd(2'b10);
    chk("R8 ack ignored while held", irqPending, 1);
    cmd(2'b11);
    chk("R11 reserved irq", irqPending, 1);
    chk("R11 reserved no dma", dmaReq, 0);
    cmd(2'b00);
    chk("R11 none code", irqPending, 1);
    errResetHeld();
    chk("R3 head popped", qHead, qTail);

    // R4 overrun with parity not special
    parityIsSpecial = 1'b0;
    push(8'h33, 3'b010); tick();
    chk("R4 overrun held", irqPending, 1);
    chk("R4 overrun status", rxStatus, 4'b1010);
    errResetHeld();

    // R5 parity combinations
    push(8'h44, 3'b001); tick();
    chk("R5 parity not special", irqPending, 0);
    chk("R5 parity status", rxStatus, 4'b0001);
    parityIsSpecial = 1'b1; parityEnable = 1'b0;
    push(8'h55, 3'b001); tick();
    chk("R5 parity disabled no irq", irqPending, 0);
    chk("R5 parity disabled status", rxStatus, 4'b0000);
    chk("R5 parity disabled delivered", rxData, 8'h55);
    parityEnable = 1'b1;
    push(8'h66, 3'b001); tick();
    chk("R5 parity special held", irqPending, 1);
    chk("R5 parity special status", rxStatus, 4'b1001);

    // R9 channel reset while held, then mode 00 delivers
    chanReset = 1'b1; modeSel = 2'b00; #1;
    chk("R9 no pop on reset", fifoPop, 0);
    tick(); chanReset = 1'b0; #1;
    chk("R9 irq cleared", irqPending, 0);
    chk("R9 status cleared", rxStatus, 0);
    chk("R6 errored char offered", dmaReq, 1);
    tick();
    chk("R6 no irq", irqPending, 0);
    chk("R6 status flags error", rxStatus, 4'b1001);
    push(8'h77, 3'b110); tick();
    chk("R6 framing delivered", rxData, 8'h77);
    chk("R6 still no irq", irqPending, 0);

    // R7 / R8 per-character modes
    modeSel = 2'b01;
    push(8'h88, 3'b000); tick();
    chk("R7 irq on clean char", irqPending, 1);
    chk("R7 clean status", rxStatus, 4'b0000);
    cmd(2'b10);
    chk("R8 ack clears", irqPending, 0);
    modeSel = 2'b10;
    push(8'h99, 3'b100);
    chk("R7 error offered", dmaReq, 1);
    tick();
    chk("R7 irq on error char", irqPending, 1);
    chk("R7 error status", rxStatus[3], 1);
    cmd(2'b10);
    dmaAck = 1'b0; tick();

    // randomized streams in error-only mode
    runRound(1'b1, 1'b1, 120);
    runRound(1'b1, 1'b0, 100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule